// File: doc/BRIEF.md
# Debug Port Serial Receiver

This block receives asynchronous serial characters on a single input line and presents them to software through a two-address register window. The line passes through a two-stage synchronizer. It is then examined on every pulse of an externally generated oversampling enable, which runs at sixteen times the bit rate. A falling edge starts a candidate frame, and the candidate is accepted only if the line is still low half a bit later. From that midpoint every further bit is sampled one full bit period after the previous one: eight data bits least significant first, an optional parity bit, then one stop bit.

Each completed character lands in a holding register. Sticky flags report four conditions: a character is waiting, a character arrived before the previous one was collected, the parity was wrong, and the stop bit was low. Reading the holding register collects the character. A control write clears the three error flags. A 3-bit mode input selects even, odd, forced-zero or forced-one parity, or no parity bit at all.

Top module: `serial_debug_rx`

## Requirements
- R1: The receive line is synchronized through two flip-flops. A low level seen on an oversampling pulse starts a candidate frame. If the line is high again on the 8th pulse after that one, the receiver returns to idle and delivers no character.
- R2: After an accepted start, data bit k (k = 0..7) is sampled 16·(k+1) pulses after the start midpoint. The first bit received is stored as bit 0 of the character.
- R3: The parity mode input `par_mode` selects the parity rule. 000 expects the data bits plus the parity bit to hold an even number of ones. 001 expects an odd number. 010 expects a parity bit of 0 and 011 a parity bit of 1. Any value 1xx means the frame has no parity bit, the stop bit follows D7 directly, and no parity check is made.
- R4: When parity is enabled and the received parity bit differs from the expected one, status bit 2 (parity error) is set.
- R5: When the stop bit has been sampled, the character is copied into the holding register and status bit 0 (ready) is set.
- R6: A read at address 0 returns the holding register and clears ready. A read at address 1 returns the status byte {4'b0, framing, parity, overrun, ready} and changes nothing.
- R7: If a character completes while ready is set and is not being read in that cycle, status bit 1 (overrun) is set. The holding register takes the newest character and ready stays set.
- R8: If the line is low at the stop-bit sample, status bit 3 (framing error) is set. The character is still stored and ready is still set.
- R9: Overrun, parity error and framing error stay set until a write to address 0 with data bit 0 at 1. That write clears all three and leaves ready and the holding register unchanged.
- R10: After reset every status bit is 0 and the holding register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| os_tick | input | 1 | Single-cycle enable at 16x the bit rate |
| par_mode | input | 3 | Parity mode, encoding as in R3 |
| bus_addr | input | 1 | Register address: 0 holding/control, 1 status |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data; bit 0 at address 0 is the reset-status control |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |

## Verification
The checker takes several things for granted. The enable arrives as isolated single-cycle pulses. The parity mode does not change while a frame is in flight. A read and a write never occur in the same cycle. A reset-status write never lands in the cycle in which a character completes; in that case the new error would win and the clear assertion would not apply. The bench keeps within these limits. It pulses the enable every second clock and holds the mode for a whole frame. It drives the line in whole bits of exactly sixteen pulses. It issues every bus access only after the frame and two idle bit times have passed, so no access can meet a completing character.

// File: rtl/dbg_rx_pkg.sv
// Package: shared state encoding, register addresses and parity helpers
// for the debug port serial receiver.
package dbg_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam logic ADDR_HOLD = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Parity bit is present unless the top mode bit is set.
    function automatic logic par_on(input logic [2:0] mode);
        return !mode[2];
    endfunction

    // Expected parity bit given the mode and the XOR of all data bits.
    function automatic logic par_expect(input logic [2:0] mode, input logic data_xor);
        case (mode[1:0])
            2'b00:   return data_xor;
            2'b01:   return !data_xor;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dbg_rx_sync.sv
// Module: two-stage synchronizer for the asynchronous receive line.
// Assumes: line idles high, so both stages reset to 1.
module dbg_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    // Shift the line through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/dbg_rx_frame.sv
// Module: frame sampler. Detects and confirms the start bit, samples data,
// optional parity and stop bits at bit midpoints, and emits a one-cycle
// done pulse with the character and its error indications.
// Assumes: os_tick pulses at OSR times the bit rate; line is synchronized.
module dbg_rx_frame
    import dbg_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic              os_tick,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bad,
    output logic              stop_bad
);
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = OSR / 2;

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        mode_q;
    logic              par_bit;
    logic              bit_end;

    assign bit_end = (cnt == CNT_W'(OSR - 1));
    assign data    = shreg;

    // Step the frame state machine on each oversampling pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            mode_q   <= '0;
            par_bit  <= 1'b0;
            done     <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            mode_q <= par_mode;
                            state <= line_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (bit_end) begin
                            cnt   <= '0;
                            shreg <= {line_s, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                            if (idx == IDX_W'(DATA_W - 1))
                                state <= par_on(mode_q) ? RX_PAR : RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (bit_end) begin
                            cnt     <= '0;
                            par_bit <= line_s;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (bit_end) begin
                            cnt      <= '0;
                            done     <= 1'b1;
                            stop_bad <= !line_s;
                            par_bad  <= par_on(mode_q) &&
                                        (par_bit != par_expect(mode_q, ^shreg));
                            state    <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dbg_rx_regs.sv
// Module: holding register, sticky status flags and the register window.
// Assumes: done is a single-cycle pulse; read and write strobes last one cycle.
module dbg_rx_regs
    import dbg_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bad,
    input  logic              stop_bad,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] hold_q,
    output logic              st_rdy,
    output logic              st_ovr,
    output logic              st_perr,
    output logic              st_ferr
);
    logic rd_hold;
    logic clr_err;

    assign rd_hold = bus_rd && (bus_addr == ADDR_HOLD);
    assign clr_err = bus_wr && (bus_addr == ADDR_HOLD) && bus_wdata[0];

    // Capture characters and maintain the flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            st_rdy  <= 1'b0;
            st_ovr  <= 1'b0;
            st_perr <= 1'b0;
            st_ferr <= 1'b0;
        end else begin
            if (done)
                hold_q <= data;
            st_rdy  <= done ? 1'b1 : (rd_hold ? 1'b0 : st_rdy);
            st_ovr  <= (done && st_rdy && !rd_hold) ? 1'b1 : (clr_err ? 1'b0 : st_ovr);
            st_perr <= (done && par_bad)  ? 1'b1 : (clr_err ? 1'b0 : st_perr);
            st_ferr <= (done && stop_bad) ? 1'b1 : (clr_err ? 1'b0 : st_ferr);
        end
    end

    // Select the addressed register for the read data bus.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_HOLD)
            bus_rdata = hold_q;
        else
            bus_rdata[3:0] = {st_ferr, st_perr, st_ovr, st_rdy};
    end
endmodule

// File: rtl/serial_debug_rx.sv
// Module: top of the debug port serial receiver. Chains synchronizer,
// frame sampler and register block.
// Assumes: DATA_W >= 4 so the status byte fits the bus.
module serial_debug_rx #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic [2:0]        par_mode,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              line_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_par_bad;
    logic              frm_stop_bad;
    logic [DATA_W-1:0] hold_q;
    logic              st_rdy;
    logic              st_ovr;
    logic              st_perr;
    logic              st_ferr;

    dbg_rx_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    dbg_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .os_tick (os_tick),
        .par_mode(par_mode),
        .done    (frm_done),
        .data    (frm_data),
        .par_bad (frm_par_bad),
        .stop_bad(frm_stop_bad)
    );

    dbg_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (frm_done),
        .data     (frm_data),
        .par_bad  (frm_par_bad),
        .stop_bad (frm_stop_bad),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hold_q   (hold_q),
        .st_rdy   (st_rdy),
        .st_ovr   (st_ovr),
        .st_perr  (st_perr),
        .st_ferr  (st_ferr)
    );
endmodule

// File: rtl/dbg_rx_chk.sv
// Module: assertion checker for serial_debug_rx, attached by bind.
// Assumes: reset-status writes never coincide with a completing character.
module dbg_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              done,
    input logic [DATA_W-1:0] hold,
    input logic              rdy,
    input logic              ovr,
    input logic              perr,
    input logic              ferr
);
    logic rd_hold;
    logic clr;
    assign rd_hold = bus_rd && !bus_addr;
    assign clr     = bus_wr && !bus_addr && bus_wdata[0];

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rdy);
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(hold));
    assert_ready_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && !done) |=> !rdy);
    assert_ready_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !rd_hold) |=> rdy);
    assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy && !rd_hold) |=> ovr);
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);
    assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr) |=> perr);
    assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !clr) |=> ferr);
    assert_clear_errs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> (!ovr && !perr && !ferr));
endmodule

bind serial_debug_rx dbg_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .done     (frm_done),
    .hold     (hold_q),
    .rdy      (st_rdy),
    .ovr      (st_ovr),
    .perr     (st_perr),
    .ferr     (st_ferr)
);

// File: tb/serial_debug_rx_tb.sv
// Bench: sweeps all 256 data values across all eight parity mode codes,
// plus targeted overrun, framing, false-start and sticky-flag cases.
module serial_debug_rx_tb;
    localparam int TICKDIV = 2;
    localparam int BITCLK  = 16 * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [2:0] par_mode = 3'b000;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    int tdiv = 0;

    serial_debug_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .par_mode(par_mode), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    // Oversampling enable: one clock in every TICKDIV.
    always @(negedge clk) begin
        tdiv    <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == 0);
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [2:0] m, input logic [7:0] d);
        case (m[1:0])
            2'b00:   return ^d;
            2'b01:   return ~^d;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] m,
                        input logic flip, input logic bad_stop);
        par_mode = m;
        drive_bit(1'b0);
        for (int k = 0; k < 8; k++) drive_bit(d[k]);
        if (!m[2]) drive_bit(exp_par(m, d) ^ flip);
        drive_bit(!bad_stop);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        bus_addr  = 1'b0;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
    endtask

    initial begin
        repeat (200000 - 5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        rd(1'b1, v); check("R10 status after reset", v, 8'h00);
        rd(1'b0, v); check("R10 holding after reset", v, 8'h00);

        // R2 R3 R4 R5 R6: every data value, mode cycles through all codes.
        for (int i = 0; i < 256; i++) begin
            logic [2:0] m;
            logic       fl;
            m  = 3'(i);
            fl = ((i % 7) == 3) && !m[2];
            send(8'(i), m, fl, 1'b0);
            rd(1'b1, v); check("R5/R4 status after frame", v, {5'b0, fl, 2'b01});
            rd(1'b0, v); check("R2/R3 holding data", v, 8'(i));
            rd(1'b1, v); check("R6 ready cleared by read", v, {5'b0, fl, 2'b00});
            if (fl) begin
                wr_ctl(8'h01);
                rd(1'b1, v); check("R9 parity flag cleared", v, 8'h00);
            end
        end

        // R7: two characters without a read.
        send(8'hA5, 3'b100, 1'b0, 1'b0);
        send(8'h3C, 3'b100, 1'b0, 1'b0);
        rd(1'b1, v); check("R7 overrun and ready", v, 8'h03);
        wr_ctl(8'h01);
        rd(1'b1, v); check("R9 clear keeps ready", v, 8'h01);
        rd(1'b0, v); check("R7 holding has newest", v, 8'h3C);
        rd(1'b1, v); check("R6 all clear", v, 8'h00);

        // R8: low stop bit.
        send(8'h96, 3'b000, 1'b0, 1'b1);
        rd(1'b1, v); check("R8 framing flag", v, 8'h09);
        rd(1'b0, v); check("R8 character stored", v, 8'h96);
        wr_ctl(8'h00);
        rd(1'b1, v); check("R9 write without bit0 ignored", v, 8'h08);
        wr_ctl(8'h01);
        rd(1'b1, v); check("R9 framing cleared", v, 8'h00);

        // R9: parity flag survives a later good frame.
        send(8'h5A, 3'b001, 1'b1, 1'b0);
        rd(1'b0, v);
        send(8'h33, 3'b001, 1'b0, 1'b0);
        rd(1'b1, v); check("R9 parity flag sticky", v, 8'h05);
        rd(1'b0, v); check("R9 later data", v, 8'h33);
        wr_ctl(8'h01);
        rd(1'b1, v); check("R9 sticky cleared", v, 8'h00);

        // R1: short low pulse is rejected.
        rx_line = 1'b0;
        repeat (4 * TICKDIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        rd(1'b1, v); check("R1 false start no char", v, 8'h00);
        send(8'h81, 3'b100, 1'b0, 1'b0);
        rd(1'b1, v); check("R1 receiver recovers", v, 8'h01);
        rd(1'b0, v); check("R1 data after glitch", v, 8'h81);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule